// File: doc/BRIEF.md
# Byte-Wide Synchronous Serial Port (Master or Slave)

The block moves one byte at a time over a four-wire synchronous serial link, acting either as the clock-generating master or as a slave clocked from outside. Software-facing logic presents a data register (write to load the outgoing byte, read to collect the incoming one), a 3-bit rate select, an enable, a role select and a 4-bit direction mask. On the pad side the clock, the two data lines and the select line each have separate input, output and output-enable signals. A pad driver is expected to combine these.

During a transfer the local shift register and the far-end shift register form one 16-bit ring. Eight clock periods rotate it by eight places, so the two bytes swap ends. As master, a prescaler divides the system clock to make the serial clock. The prescaler counts only while a master transfer is under way and is held at zero otherwise. As slave, the block follows the serial clock it receives and shifts only while its select input is low. Every output pad is driven only if the role makes it an output and its direction bit is 1. With its direction bit at 0, an output pad stays undriven, and its level can be used as a general-purpose input. A single data pad can therefore be turned around with its direction bit.

The control is a four-state machine:
- `ST_IDLE` waits.
- `ST_LO` is the clock-low half of a bit.
- `ST_HI` is the clock-high half of a bit.
- `ST_HOLD` is a slave that has finished its byte and is still selected.

The transitions are:
- `ST_IDLE` to `ST_LO`: a master write is accepted, or the slave select falls.
- `ST_LO` to `ST_HI`: a rising clock event.
- `ST_HI` to `ST_LO`: a falling clock event before the last bit.
- `ST_HI` to `ST_IDLE`: the last falling event in master role.
- `ST_HI` to `ST_HOLD`: the last falling event in slave role.
- `ST_HOLD` to `ST_IDLE`: the select rises.
- `ST_LO` or `ST_HI` to `ST_IDLE`: the select rises in slave role (abort).
- Any state to `ST_IDLE`: the enable is cleared.

Top module: `spi_port`

## Requirements
- R1: In master role the serial clock idles low. Each high and each low half lasts 2^sel system clocks, where `cfg_baud` = sel, giving a period of 2^(sel+1) clocks (2 to 256). A transfer has exactly 8 high halves.
- R2: The prescaler counts only while a master transfer is active. The first rising edge of `sck_o` therefore comes exactly 2^sel clocks after the clock edge that accepts the write, and `sck_o` stays low whenever `busy` is 0.
- R3: Data moves MSB first. The outgoing bit changes after the falling edge, and the incoming bit is sampled at the rising edge. After a master transfer, `rd_data` holds the byte the slave sent, and the slave holds the byte that was written.
- R4: A data write while `busy` is 1 is ignored. It changes neither the byte sent nor the byte received.
- R5: `done` becomes 1 on the clock edge that ends the eighth bit, and `rd_data` is valid from that cycle. A pulse on `rd_en` clears `done`.
- R6: Direction bit mapping is bit0 clock, bit1 MOSI, bit2 MISO, bit3 select. In enabled master role, `sck_oe`, `mosi_oe` and `ss_oe` follow their direction bits. `miso_oe` is 0 whatever bit2 holds.
- R7: In enabled slave role, clock, MOSI and select are inputs (output enables 0) whatever their direction bits. `miso_oe` is 1 only while `ss_i` is low and direction bit2 is 1.
- R8: A slave shifts only on received clock edges while `ss_i` is low. Eight of them swap its preloaded byte with the master's byte. Clock edges while `ss_i` is high change neither `rd_data` nor `done`.
- R9: Clearing `cfg_en` aborts a transfer within one clock. `busy` and `done` go to 0 and all output enables release. The next transfer then runs a full eight bits.
- R10: In master role `ss_o` is low for the whole transfer and high when idle.
- R11: After reset, `busy`, `done`, `sck_o` and all output enables are 0, and `ss_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Port enable |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_baud | input | BAUD_W | Rate select; half period = 2^value clocks |
| cfg_dir | input | 4 | Direction mask: bit0 clock, bit1 MOSI, bit2 MISO, bit3 select |
| wr_en | input | 1 | Load `wr_data` into the shift register (idle only) |
| wr_data | input | DATA_W | Byte to send |
| rd_en | input | 1 | Read strobe; clears `done` |
| rd_data | output | DATA_W | Shift register contents / received byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Byte complete, not yet read |
| sck_i | input | 1 | Clock pad input |
| sck_o | output | 1 | Clock pad output |
| sck_oe | output | 1 | Clock pad drive enable |
| mosi_i | input | 1 | Master-out data pad input |
| mosi_o | output | 1 | Master-out data pad output |
| mosi_oe | output | 1 | Master-out data pad drive enable |
| miso_i | input | 1 | Master-in data pad input |
| miso_o | output | 1 | Master-in data pad output |
| miso_oe | output | 1 | Master-in data pad drive enable |
| ss_i | input | 1 | Select pad input (active low) |
| ss_o | output | 1 | Select pad output |
| ss_oe | output | 1 | Select pad drive enable |

## Verification
The bench builds the block with its defaults: 8-bit data, a 3-bit rate select and two synchronizer stages. The table walks rate selects 0, 1, 2, 3, 5 and 7, so both the single-clock half period and the longest 128-clock half period (divide by 256) are measured edge for edge within the run budget. Two stages put about three clocks of latency on each received slave clock edge. That is why the bench drives the slave clock with eight-clock halves, and it makes the synchronizer delay part of what the slave-mode checks must tolerate.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LO,
        ST_HI,
        ST_HOLD
    } spi_state_e;

    // Bit positions inside the direction mask
    localparam int DIR_SCK  = 0;
    localparam int DIR_MOSI = 1;
    localparam int DIR_MISO = 2;
    localparam int DIR_SS   = 3;
    localparam int DIR_W    = 4;

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int             W      = 3,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[0] <= RST_VAL;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= RST_VAL;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_baud_div.sv
module spi_baud_div #(
    parameter int BAUD_W = 3,
    localparam int CNT_W = (1 << BAUD_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [BAUD_W-1:0] sel,
    output logic              tick,
    output logic [CNT_W-1:0]  cnt_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   lim;

    // Last count of a half period: 2^sel - 1
    assign lim  = ({{CNT_W{1'b0}}, 1'b1} << sel) - 1'b1;
    assign tick = run && ({1'b0, cnt_q} == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!run || tick)   cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/spi_pin_gate.sv
module spi_pin_gate
    import spi_port_pkg::*;
(
    input  logic             en,
    input  logic             master,
    input  logic             ss_pad,
    input  logic [DIR_W-1:0] dir,
    output logic             sck_oe,
    output logic             mosi_oe,
    output logic             miso_oe,
    output logic             ss_oe
);

    always_comb begin
        sck_oe  = 1'b0;
        mosi_oe = 1'b0;
        miso_oe = 1'b0;
        ss_oe   = 1'b0;
        if (en) begin
            if (master) begin
                sck_oe  = dir[DIR_SCK];
                mosi_oe = dir[DIR_MOSI];
                ss_oe   = dir[DIR_SS];
            end else begin
                miso_oe = dir[DIR_MISO] && !ss_pad;
            end
        end
    end

endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int BAUD_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_master,
    input  logic [BAUD_W-1:0] cfg_baud,
    input  logic [3:0]        cfg_dir,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              ss_i,
    output logic              ss_o,
    output logic              ss_oe
);

    localparam int CNT_W = (1 << BAUD_W) - 1;
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    spi_state_e        state_q, state_d;
    logic [DATA_W-1:0] shreg_q;
    logic              samp_q;
    logic [BIT_W-1:0]  bit_q;
    logic              done_q;
    logic              sck_prev_q;

    logic              sck_s, mosi_s, ss_s;
    logic              sck_rise, sck_fall;
    logic              tick;
    logic [CNT_W-1:0]  div_cnt;
    logic              rise_ev, fall_ev;
    logic              slave_drop, wr_ok, lo_rise, hi_fall;

    // Received slave-side pins into the clock domain
    spi_in_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck_i, mosi_i, ss_i}),
        .q     ({sck_s, mosi_s, ss_s})
    );

    spi_baud_div #(
        .BAUD_W (BAUD_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cfg_en && cfg_master && (state_q != ST_IDLE)),
        .sel   (cfg_baud),
        .tick  (tick),
        .cnt_o (div_cnt)
    );

    spi_pin_gate u_gate (
        .en      (cfg_en),
        .master  (cfg_master),
        .ss_pad  (ss_i),
        .dir     (cfg_dir),
        .sck_oe  (sck_oe),
        .mosi_oe (mosi_oe),
        .miso_oe (miso_oe),
        .ss_oe   (ss_oe)
    );

    assign sck_rise   = sck_s && !sck_prev_q;
    assign sck_fall   = !sck_s && sck_prev_q;
    assign rise_ev    = cfg_master ? tick : sck_rise;
    assign fall_ev    = cfg_master ? tick : sck_fall;
    assign slave_drop = !cfg_master && ss_s;
    assign wr_ok      = cfg_en && wr_en && (state_q == ST_IDLE) && (cfg_master || ss_s);
    assign lo_rise    = cfg_en && (state_q == ST_LO) && !slave_drop && rise_ev;
    assign hi_fall    = cfg_en && (state_q == ST_HI) && !slave_drop && fall_ev;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (!cfg_en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cfg_master) begin
                        if (wr_en) state_d = ST_LO;
                    end else if (!ss_s) begin
                        state_d = ST_LO;
                    end
                end
                ST_LO: begin
                    if (slave_drop)   state_d = ST_IDLE;
                    else if (rise_ev) state_d = ST_HI;
                end
                ST_HI: begin
                    if (slave_drop) begin
                        state_d = ST_IDLE;
                    end else if (fall_ev) begin
                        if (bit_q == LAST_BIT) state_d = cfg_master ? ST_IDLE : ST_HOLD;
                        else                   state_d = ST_LO;
                    end
                end
                ST_HOLD: begin
                    if (cfg_master || ss_s) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q    <= '0;
            samp_q     <= 1'b0;
            bit_q      <= '0;
            done_q     <= 1'b0;
            sck_prev_q <= 1'b0;
        end else begin
            sck_prev_q <= sck_s;
            if (!cfg_en) begin
                bit_q  <= '0;
                done_q <= 1'b0;
            end else begin
                if (rd_en)                bit_q <= bit_q;
                if (rd_en)                done_q <= 1'b0;
                if (state_q == ST_IDLE)   bit_q <= '0;
                if (wr_ok)                shreg_q <= wr_data;
                if (lo_rise)              samp_q <= cfg_master ? miso_i : mosi_s;
                if (hi_fall) begin
                    shreg_q <= {shreg_q[DATA_W-2:0], samp_q};
                    bit_q   <= bit_q + 1'b1;
                    if (bit_q == LAST_BIT) done_q <= 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        sck_o   = cfg_master && (state_q == ST_HI);
        ss_o    = !(cfg_master && (state_q != ST_IDLE));
        mosi_o  = shreg_q[DATA_W-1];
        miso_o  = shreg_q[DATA_W-1];
        busy    = (state_q != ST_IDLE);
        done    = done_q;
        rd_data = shreg_q;
    end

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_en,
    input logic             cfg_master,
    input logic             rd_en,
    input logic             busy,
    input logic             done,
    input logic             sck_o,
    input logic             sck_oe,
    input logic             mosi_oe,
    input logic             miso_oe,
    input logic             ss_oe,
    input logic [CNT_W-1:0] div_cnt
);

    // R2
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck_o);

    // R2
    div_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_en && cfg_master && busy) |=> (div_cnt == '0));

    // R9
    disabled_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> !(sck_oe || mosi_oe || miso_oe || ss_oe));

    // R9
    disable_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !busy && !done);

    // R6
    master_miso_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && cfg_master) |-> !miso_oe);

    // R7
    slave_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && !cfg_master) |-> !(sck_oe || mosi_oe || ss_oe));

    // R5
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && done && !busy) |=> !done);

    // R1
    sck_master_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> cfg_master);

endmodule

bind spi_port spi_port_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_en     (cfg_en),
    .cfg_master (cfg_master),
    .rd_en      (rd_en),
    .busy       (busy),
    .done       (done),
    .sck_o      (sck_o),
    .sck_oe     (sck_oe),
    .mosi_oe    (mosi_oe),
    .miso_oe    (miso_oe),
    .ss_oe      (ss_oe),
    .div_cnt    (div_cnt)
);

// File: tb/spi_port_tb.sv
module spi_port_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_en, cfg_master;
    logic [2:0] cfg_baud;
    logic [3:0] cfg_dir;
    logic       wr_en, rd_en;
    logic [7:0] wr_data, rd_data;
    logic       busy, done;
    logic       sck_i, sck_o, sck_oe;
    logic       mosi_i, mosi_o, mosi_oe;
    logic       miso_i, miso_o, miso_oe;
    logic       ss_i, ss_o, ss_oe;

    int nvec = 0;
    int nbad = 0;

    always #4 clk = ~clk;

    spi_port u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_master(cfg_master),
        .cfg_baud(cfg_baud), .cfg_dir(cfg_dir), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .busy(busy), .done(done),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .ss_i(ss_i), .ss_o(ss_o), .ss_oe(ss_oe)
    );

    // Behavioural far-end slave used in master tests
    logic [7:0] bslv;
    logic       bcap;
    logic       slv_load = 1'b0;
    logic [7:0] slv_val  = 8'h00;

    assign miso_i = bslv[7];
    always @(posedge sck_o) bcap = mosi_o;
    always @(negedge sck_o or posedge slv_load) begin
        if (slv_load) bslv = slv_val;
        else          bslv = {bslv[6:0], bcap};
    end

    // {sel, master byte, slave byte}
    localparam logic [18:0] VEC [6] = '{
        {3'd0, 8'hA5, 8'h5A},
        {3'd1, 8'h81, 8'h7E},
        {3'd2, 8'h00, 8'hFF},
        {3'd7, 8'hC3, 8'h3C},
        {3'd3, 8'hFF, 8'h00},
        {3'd5, 8'h96, 8'h69}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic load_slave(input logic [7:0] b);
        slv_val = b; slv_load = 1'b1; #1; slv_load = 1'b0;
    endtask

    task automatic master_xfer(input logic [2:0] sel, input logic [7:0] mb,
                               input logic [7:0] sb, output int hicnt, output int lead);
        bit seen_hi;
        load_slave(sb);
        cfg_baud = sel;
        do_write(mb);
        hicnt = 0; lead = 0; seen_hi = 0;
        while (!done) begin
            if (sck_o) begin hicnt++; seen_hi = 1; end
            else if (!seen_hi) lead++;
            @(negedge clk);
        end
    endtask

    task automatic slave_xfer(input logic [7:0] pre, input logic [7:0] sendb);
        logic [7:0] got;
        do_write(pre);
        @(negedge clk); ss_i = 1'b0;
        repeat (8) @(negedge clk);
        chk("R7 miso_oe when selected", {31'd0, miso_oe}, 32'd1);
        chk("R8 busy when selected", {31'd0, busy}, 32'd1);
        for (int i = 7; i >= 0; i--) begin
            mosi_i = sendb[i];
            repeat (6) @(negedge clk);
            got[i] = miso_o;
            sck_i = 1'b1;
            repeat (8) @(negedge clk);
            sck_i = 1'b0;
        end
        repeat (8) @(negedge clk);
        chk("R8 slave done", {31'd0, done}, 32'd1);
        chk("R8 slave received", {24'd0, rd_data}, {24'd0, sendb});
        chk("R3 slave sent MSB first", {24'd0, got}, {24'd0, pre});
        ss_i = 1'b1;
        repeat (6) @(negedge clk);
        chk("R8 slave idle after deselect", {31'd0, busy}, 32'd0);
        do_read();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        int hc, ld;
        rst_n = 1'b0; cfg_en = 1'b0; cfg_master = 1'b1; cfg_baud = 3'd0;
        cfg_dir = 4'hF; wr_en = 1'b0; rd_en = 1'b0; wr_data = 8'h00;
        sck_i = 1'b0; mosi_i = 1'b0; ss_i = 1'b1;
        repeat (4) @(negedge clk);
        // R11 reset state
        chk("R11 busy", {31'd0, busy}, 32'd0);
        chk("R11 done", {31'd0, done}, 32'd0);
        chk("R11 sck_o", {31'd0, sck_o}, 32'd0);
        chk("R11 ss_o", {31'd0, ss_o}, 32'd1);
        chk("R11 oes", {28'd0, ss_oe, miso_oe, mosi_oe, sck_oe}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        cfg_en = 1'b1;
        @(negedge clk);

        // R6 master output enables
        chk("R6 master dir=F", {28'd0, ss_oe, miso_oe, mosi_oe, sck_oe}, 32'hB);
        cfg_dir = 4'b0101; #1;
        chk("R6 master dir=5", {28'd0, ss_oe, miso_oe, mosi_oe, sck_oe}, 32'h1);
        cfg_dir = 4'hF;
        chk("R10 ss_o idle high", {31'd0, ss_o}, 32'd1);

        // Table-driven master transfers: R1 R2 R3 R5
        foreach (VEC[v]) begin
            master_xfer(VEC[v][18:16], VEC[v][15:8], VEC[v][7:0], hc, ld);
            chk("R1 high clocks", hc, 32'(8 << VEC[v][18:16]));
            chk("R2 lead clocks", ld, 32'(1 << VEC[v][18:16]));
            chk("R3 master received", {24'd0, rd_data}, {24'd0, VEC[v][7:0]});
            chk("R3 slave received", {24'd0, bslv}, {24'd0, VEC[v][15:8]});
            chk("R5 done set", {31'd0, done}, 32'd1);
            chk("R2 sck low when idle", {31'd0, sck_o}, 32'd0);
            do_read();
            chk("R5 done cleared", {31'd0, done}, 32'd0);
        end

        // R10 select low during transfer, R4 write ignored while busy
        load_slave(8'h42);
        cfg_baud = 3'd1;
        do_write(8'hA5);
        repeat (3) @(negedge clk);
        chk("R10 ss_o low in transfer", {31'd0, ss_o}, 32'd0);
        do_write(8'h3C);
        while (!done) @(negedge clk);
        chk("R4 received unchanged", {24'd0, rd_data}, 32'h42);
        chk("R4 sent unchanged", {24'd0, bslv}, 32'hA5);
        chk("R10 ss_o high after", {31'd0, ss_o}, 32'd1);
        do_read();

        // R9 abort by clearing enable
        load_slave(8'h11);
        cfg_baud = 3'd3;
        do_write(8'hEE);
        repeat (20) @(negedge clk);
        cfg_en = 1'b0;
        @(negedge clk);
        chk("R9 busy after abort", {31'd0, busy}, 32'd0);
        chk("R9 done after abort", {31'd0, done}, 32'd0);
        chk("R9 oes released", {28'd0, ss_oe, miso_oe, mosi_oe, sck_oe}, 32'd0);
        cfg_en = 1'b1;
        master_xfer(3'd2, 8'h5C, 8'hC5, hc, ld);
        chk("R9 full transfer after abort", hc, 32'd32);
        chk("R9 received after abort", {24'd0, rd_data}, 32'hC5);
        chk("R9 sent after abort", {24'd0, bslv}, 32'h5C);
        do_read();

        // Slave role: R7 R8
        cfg_master = 1'b0;
        repeat (4) @(negedge clk);
        chk("R7 slave deselected oes", {28'd0, ss_oe, miso_oe, mosi_oe, sck_oe}, 32'd0);
        do_write(8'h9A);
        // clock edges while deselected must do nothing
        for (int i = 0; i < 8; i++) begin
            sck_i = 1'b1; repeat (4) @(negedge clk);
            sck_i = 1'b0; repeat (4) @(negedge clk);
        end
        chk("R8 no shift while ss high", {24'd0, rd_data}, 32'h9A);
        chk("R8 no done while ss high", {31'd0, done}, 32'd0);
        cfg_dir = 4'b1011;
        ss_i = 1'b0; #1;
        chk("R7 miso_oe needs dir bit2", {31'd0, miso_oe}, 32'd0);
        ss_i = 1'b1;
        cfg_dir = 4'hF;
        repeat (6) @(negedge clk);
        slave_xfer(8'hB4, 8'h2D);
        slave_xfer(8'h01, 8'h80);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule